// File: doc/BRIEF.md
# Byte-lane asynchronous SRAM core

This block is a synthesizable functional stand-in for a word-wide static memory with two byte lanes. Every control is active-low: chip select, write enable, output enable, plus one enable per byte lane. The three-state data pins are replaced by a separate write-data input, a read-data output and a two-bit drive-enable vector. A pad ring or a bus model can rebuild the bidirectional pins from these three.

Reads are purely combinational from the current address and controls. A write is committed on the rising clock edge whenever the write condition holds at that edge. Only the byte lanes whose enables are low are written. While write enable is low, the data outputs never drive. An active-low reset inhibits writes and does not clear the stored contents. The address width is a parameter. Set to 16, it gives the full 65,536-word organisation. The default is smaller so that elaboration stays light.

Top module: `lane_sram`

## Requirements
- R1: The store holds 2**ADDR_W words of 16 bits (LANE_W=8). Lane 0 is bits 7:0 and is governed by byteEnN[0]. Lane 1 is bits 15:8 and is governed by byteEnN[1]. Every address keeps its own word.
- R2: With chipSelN=1, drvEn is 2'b00 and rdData is zero whatever the other inputs are, and no rising edge changes the stored contents.
- R3: With chipSelN=0, writeEnN=1 and outEnN=0, drvEn[i] equals ~byteEnN[i], and each driving lane shows the stored byte at addr.
- R4: On a rising edge with chipSelN=0, writeEnN=0 and rstN=1, every lane i with byteEnN[i]=0 takes wrData's lane i, and the other lane keeps its old value.
- R5: While writeEnN=0, drvEn is 2'b00 whatever outEnN is, including a write that starts at the same moment as the select.
- R6: With outEnN=1 and writeEnN=1, drvEn is 2'b00. With both byte enables high, drvEn is 2'b00 and no lane is written.
- R7: A lane whose drvEn bit is 0 shows zero on its bits of rdData.
- R8: While rstN=0, no rising edge writes the store, and reset does not alter the stored contents.
- R9: rdData follows a change of addr with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write commit clock (rising edge) |
| rstN | input | 1 | Active-low write inhibit |
| chipSelN | input | 1 | Active-low chip select |
| writeEnN | input | 1 | Active-low write enable |
| outEnN | input | 1 | Active-low output enable |
| byteEnN | input | 2 | Active-low lane enables; bit 0 low byte, bit 1 high byte |
| addr | input | ADDR_W | Word address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, zero on non-driving lanes |
| drvEn | output | 2 | Per-lane drive enable standing in for the three-state pins |

## Verification
The bench overrides ADDR_W to 6, so the store has 64 words. This lets it fill and read back every address and check that each word is distinct. Every control row runs against a per-byte shadow, with its own address and data pattern. Because the store is this small, the byte-merge checks can reach every address without running long, and the combinational-read and reset-inhibit corners stay short directed sequences.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
  localparam int NUM_LANES = 2;

  typedef struct packed {
    logic [NUM_LANES-1:0] wrLane;
    logic [NUM_LANES-1:0] rdLane;
  } laneStrobes_t;
endpackage

// File: rtl/lane_ctl.sv
module lane_ctl
  import lane_sram_pkg::*;
(
  input  logic                 rstN,
  input  logic                 chipSelN,
  input  logic                 writeEnN,
  input  logic                 outEnN,
  input  logic [NUM_LANES-1:0] byteEnN,
  output laneStrobes_t         strobes
);
  logic selected;
  logic writing;
  logic reading;

  assign selected = ~chipSelN;
  // write wins over output enable: a low write enable blocks every driver
  assign writing  = selected & ~writeEnN;
  assign reading  = selected & writeEnN & ~outEnN;

  always_comb begin
    strobes.wrLane = (writing & rstN) ? ~byteEnN : '0;
    strobes.rdLane = reading ? ~byteEnN : '0;
  end
endmodule

// File: rtl/lane_store.sv
module lane_store
  import lane_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = NUM_LANES * LANE_W
) (
  input  logic              clk,
  input  laneStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  for (genvar lane = 0; lane < NUM_LANES; lane++) begin : gLane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (strobes.wrLane[lane]) begin
        bank[addr] <= wrData[lane*LANE_W +: LANE_W];
      end
    end

    assign rdData[lane*LANE_W +: LANE_W] =
      strobes.rdLane[lane] ? bank[addr] : '0;
  end
endmodule

// File: rtl/lane_sram.sv
module lane_sram
  import lane_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  localparam int DATA_W = NUM_LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chipSelN,
  input  logic                 writeEnN,
  input  logic                 outEnN,
  input  logic [NUM_LANES-1:0] byteEnN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_LANES-1:0] drvEn
);
  laneStrobes_t strobes;

  lane_ctl ctlI (
    .rstN     (rstN),
    .chipSelN (chipSelN),
    .writeEnN (writeEnN),
    .outEnN   (outEnN),
    .byteEnN  (byteEnN),
    .strobes  (strobes)
  );

  lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) storeI (
    .clk     (clk),
    .strobes (strobes),
    .addr    (addr),
    .wrData  (wrData),
    .rdData  (rdData)
  );

  assign drvEn = strobes.rdLane;
endmodule

// File: rtl/lane_sram_chk.sv
module lane_sram_chk
  import lane_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  localparam int DATA_W = NUM_LANES * LANE_W
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 chipSelN,
  input logic                 writeEnN,
  input logic                 outEnN,
  input logic [NUM_LANES-1:0] byteEnN,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wrData,
  input logic [DATA_W-1:0]    rdData,
  input logic [NUM_LANES-1:0] drvEn
);
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    chipSelN |-> (drvEn == '0 && rdData == '0)); // R2

  AST_READ_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSelN && writeEnN && !outEnN) |-> drvEn == ~byteEnN); // R3

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !writeEnN |-> drvEn == '0); // R5

  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (outEnN || byteEnN == '1) |-> drvEn == '0); // R6

  for (genvar lane = 0; lane < NUM_LANES; lane++) begin : gChk
    AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      !drvEn[lane] |-> rdData[lane*LANE_W +: LANE_W] == '0); // R7

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
      (!chipSelN && !writeEnN && !byteEnN[lane]) |=>
        ((!chipSelN && writeEnN && !outEnN && !byteEnN[lane] && addr == $past(addr))
          |-> rdData[lane*LANE_W +: LANE_W] == $past(wrData[lane*LANE_W +: LANE_W]))); // R4
  end
endmodule

bind lane_sram lane_sram_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) chkI (.*);

// File: tb/tb_lane_sram.sv
module tb_lane_sram;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSelN = 1'b1, writeEnN = 1'b1, outEnN = 1'b1;
  logic [1:0] byteEnN = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic [1:0] drvEn;

  logic [DW-1:0] shadow [DEPTH];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lane_sram #(.ADDR_W(AW), .LANE_W(8)) dut (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .writeEnN(writeEnN),
    .outEnN(outEnN), .byteEnN(byteEnN), .addr(addr), .wrData(wrData),
    .rdData(rdData), .drvEn(drvEn)
  );

  // {cs, we, oe, beHi, beLo, drvHi, drvLo, wrHi, wrLo}
  localparam logic [8:0] ROWS [11] = '{
    9'b1_0_0_00_00_00,  // deselected, write attempt ignored
    9'b0_1_0_10_01_00,  // low byte read
    9'b0_1_0_01_10_00,  // high byte read
    9'b0_1_0_00_11_00,  // word read
    9'b0_0_0_00_00_11,  // word write with output enable low
    9'b0_0_1_10_00_01,  // low byte write
    9'b0_0_1_01_00_10,  // high byte write
    9'b0_1_1_00_00_00,  // outputs disabled by output enable
    9'b0_1_0_11_00_00,  // outputs disabled by byte enables
    9'b0_0_0_11_00_00,  // write with no lane enabled
    9'b1_1_0_00_00_00   // deselected read
  };

  function automatic logic [DW-1:0] laneMask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    chipSelN = 1'b1; writeEnN = 1'b1; outEnN = 1'b1; byteEnN = 2'b11;
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
    @(negedge clk);
    addr = a; wrData = d; chipSelN = 1'b0; writeEnN = 1'b0; outEnN = 1'b0; byteEnN = be;
    @(posedge clk);
    #1;
    if (rstN) shadow[a] = (shadow[a] & ~laneMask(~be)) | (d & laneMask(~be));
    idle();
  endtask

  task automatic readChk(input string tag, input logic [AW-1:0] a, input logic [1:0] be);
    @(negedge clk);
    addr = a; chipSelN = 1'b0; writeEnN = 1'b1; outEnN = 1'b0; byteEnN = be;
    #1;
    chk({tag, " drv"}, {14'd0, drvEn}, {14'd0, ~be});
    chk({tag, " data"}, rdData, shadow[a] & laneMask(~be));
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // reset state: deselected, nothing driven
    repeat (2) @(negedge clk);
    #1;
    chk("R2 reset drv", {14'd0, drvEn}, '0);
    chk("R7 reset data", rdData, '0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: fill every word, then read each one back
    for (int a = 0; a < DEPTH; a++) begin
      shadow[a] = '0;
      doWrite(AW'(a), 16'(a * 16'h0101) ^ 16'h3C00, 2'b00);
    end
    for (int a = 0; a < DEPTH; a++) readChk("R1 fill readback", AW'(a), 2'b00);

    // control table walk
    for (int r = 0; r < 11; r++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic [1:0] expDrv, expWr;
      a = AW'(r + 3);
      d = 16'(r * 37) ^ 16'h5AC3;
      expDrv = ROWS[r][3:2];
      expWr = ROWS[r][1:0];
      @(negedge clk);
      addr = a; wrData = d;
      chipSelN = ROWS[r][8]; writeEnN = ROWS[r][7]; outEnN = ROWS[r][6]; byteEnN = ROWS[r][5:4];
      #1;
      chk("R3 R5 R6 row drv", {14'd0, drvEn}, {14'd0, expDrv});
      chk("R7 row data", rdData, shadow[a] & laneMask(expDrv));
      @(posedge clk);
      #1;
      shadow[a] = (shadow[a] & ~laneMask(expWr)) | (d & laneMask(expWr));
      idle();
      readChk("R4 R2 row readback", a, 2'b00);
    end

    // R4: byte merge on one word, then each lane alone
    doWrite(6'd40, 16'hFFFF, 2'b00);
    doWrite(6'd40, 16'h1234, 2'b10);
    readChk("R4 merge low", 6'd40, 2'b00);
    doWrite(6'd40, 16'hAB00, 2'b01);
    readChk("R4 merge high", 6'd40, 2'b00);
    readChk("R7 lane1 only", 6'd40, 2'b01);

    // R5: select and write enable fall together, output enable low
    @(negedge clk);
    addr = 6'd41; chipSelN = 1'b0; writeEnN = 1'b0; outEnN = 1'b0; byteEnN = 2'b00;
    #1;
    chk("R5 simultaneous write drv", {14'd0, drvEn}, '0);
    chk("R5 simultaneous write data", rdData, '0);
    wrData = 16'hC0DE;
    @(posedge clk);
    #1;
    shadow[41] = 16'hC0DE;
    idle();
    readChk("R5 write after simultaneous", 6'd41, 2'b00);

    // R9: address change with no clock edge
    @(negedge clk);
    chipSelN = 1'b0; writeEnN = 1'b1; outEnN = 1'b0; byteEnN = 2'b00;
    addr = 6'd10;
    #1;
    chk("R9 first addr", rdData, shadow[10]);
    addr = 6'd11;
    #1;
    chk("R9 second addr", rdData, shadow[11]);
    idle();

    // R8: writes inhibited in reset, contents kept
    @(negedge clk);
    rstN = 1'b0;
    doWrite(6'd20, 16'hDEAD, 2'b00);
    @(negedge clk);
    rstN = 1'b1;
    readChk("R8 reset write blocked", 6'd20, 2'b00);
    readChk("R8 contents kept", 6'd21, 2'b00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule